// File: doc/BRIEF.md
# Flash Access Protection Checker

This block sits between the bus fabric and a flash array and decides, within the same cycle, whether each access to the flash address space may go ahead. The checks are applied together: a global readout-protection level, two execute-only address windows on 512-byte granularity, a per-page write-protect mask, and a securable boot region counted in whole 2 KB pages. If any check refuses the access, the block returns zero read data, blocks the write strobe and raises a violation flag for one cycle.

The block also holds the current protection level. Software asks for a new level through a request strobe. Only certain level changes are accepted, and any other request leaves the level as it is. The change from level 1 to level 0 raises an erase request. A separate erase flag, gated by a configuration bit, says whether the execute-only windows are included in that erase. The securable region locks the first time the CPU fetches code from outside it, and it stays locked until reset. Storage of the option settings and the erase itself are handled outside this block.

Top module: `flash_guard`

## Requirements
- R1: After reset, `lvl_cur` holds the level given by `lvl_init`. The codes are 2'b00 for level 0, 2'b01 for level 1 and 2'b10 for level 2. An input code of 2'b11 counts as level 1, and `lvl_cur` never shows 2'b11.
- R2: A one-cycle `lvl_req` with `lvl_req_code` sets the new level in the cycle that follows. The accepted changes are 0→2, 1→2, 0→1 and 1→0. A requested code of 2'b11 is read as level 1.
- R3: Every other request, including any request made at level 2 and any request for the current level, is ignored, and `lvl_cur` keeps its value.
- R4: An accepted 1→0 change raises `erase_req` for exactly one cycle, in the same cycle that `lvl_cur` changes. `erase_xo` pulses with it when `xo_erase_sel` is 1 and stays 0 when `xo_erase_sel` is 0.
- R5: At level 1 or level 2, an access is denied if it comes from the debugger (`acc_dbg`=1) or if `boot_src` is not 2'b00 (boot from flash). At level 0 these accesses are granted.
- R6: Each execute-only window covers the 512-byte units `acc_addr[ADDR_W-1:9]` from its low bound to its high bound, both bounds included. A window is active only when low ≤ high. Inside an active window, only a CPU instruction fetch (`acc_kind`=2'b00, `acc_dbg`=0) is granted.
- R7: A write or erase access (`acc_kind`=2'b10, with 2'b11 treated the same way) to a 2 KB page `acc_addr[ADDR_W-1:11]` whose `wp_mask` bit is set is denied. Fetches and reads of that page are not affected.
- R8: The securable region is pages 0 to `sec_pages`-1. It is accessible until the first CPU fetch to an address outside it. After that fetch, every access to the region is denied until reset.
- R9: When an access is denied, `grant`=0, `rd_data`=0 and `wr_en`=0 in the same cycle. `violation` is then 1 for exactly the following cycle, once for each denied access.
- R10: When an access is granted, `grant`=1. A fetch or read (`acc_kind`=2'b00 or 2'b01) passes `mem_rdata` to `rd_data`, and a write asserts `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_init | input | 2 | Level code loaded at reset |
| lvl_req | input | 1 | Level change request strobe |
| lvl_req_code | input | 2 | Requested level code |
| xo_erase_sel | input | 1 | Include execute-only windows in the 1→0 erase |
| boot_src | input | 2 | Boot source: 00 flash, 01 SRAM, 10/11 loader |
| xo_a_lo | input | ADDR_W-9 | Window A low bound, in 512-byte units |
| xo_a_hi | input | ADDR_W-9 | Window A high bound, in 512-byte units |
| xo_b_lo | input | ADDR_W-9 | Window B low bound, in 512-byte units |
| xo_b_hi | input | ADDR_W-9 | Window B high bound, in 512-byte units |
| wp_mask | input | 2**(ADDR_W-11) | Write-protect bit for each page |
| sec_pages | input | ADDR_W-10 | Size of the securable region, in pages |
| acc_valid | input | 1 | Access present |
| acc_kind | input | 2 | Access type: 00 fetch, 01 read, 10/11 write or erase |
| acc_dbg | input | 1 | Access comes from the debugger |
| acc_addr | input | ADDR_W | Byte address |
| mem_rdata | input | DATA_W | Read data from the array |
| grant | output | 1 | Access allowed (same cycle) |
| rd_data | output | DATA_W | Read data, forced to zero when not granted |
| wr_en | output | 1 | Write strobe for a granted write |
| violation | output | 1 | One-cycle pulse after a denied access |
| lvl_cur | output | 2 | Current protection level |
| erase_req | output | 1 | One-cycle erase request on a 1→0 change |
| erase_xo | output | 1 | The erase also covers the execute-only windows |

## Verification
The bench builds the block with ADDR_W=14, so the address space is 16 KB: eight 2 KB pages and thirty-two 512-byte execute-only units. With this size, the topmost write-protect bit, a securable region spanning every page, and execute-only windows near both ends of the address space can all be reached with short directed accesses. DATA_W keeps its default of 32. Level changes are tried from every starting level, including both erase-select settings and the 2'b11 code.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [1:0] {
        LVL0 = 2'b00,
        LVL1 = 2'b01,
        LVL2 = 2'b10
    } lvl_e;

    localparam logic [1:0] KIND_FETCH = 2'b00;
    localparam logic [1:0] BOOT_FLASH = 2'b00;

    // code 2'b11 folds onto level 1
    function automatic lvl_e lvl_norm(input logic [1:0] code);
        case (code)
            2'b00:   return LVL0;
            2'b10:   return LVL2;
            default: return LVL1;
        endcase
    endfunction

    function automatic logic lvl_step_ok(input lvl_e from, input lvl_e to);
        case (from)
            LVL0:    return (to == LVL1) || (to == LVL2);
            LVL1:    return (to == LVL0) || (to == LVL2);
            default: return 1'b0;
        endcase
    endfunction

    typedef struct packed {
        lvl_e lvl;
        logic erase;
        logic erase_xo;
    } lvl_state_t;

    typedef struct packed {
        logic viol;
        logic sec_lock;
    } guard_state_t;

endpackage

// File: rtl/fg_range_match.sv
module fg_range_match #(
    parameter int UW = 8
) (
    input  logic [UW-1:0] unit_idx,
    input  logic [UW-1:0] lo,
    input  logic [UW-1:0] hi,
    output logic          hit
);
    always_comb begin
        hit = (lo <= hi) && (unit_idx >= lo) && (unit_idx <= hi);
    end
endmodule

// File: rtl/fg_level_ctl.sv
module fg_level_ctl
    import flash_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lvl_init,
    input  logic       req,
    input  logic [1:0] req_code,
    input  logic       xo_sel,
    output lvl_e       lvl,
    output logic       erase,
    output logic       erase_xo
);
    lvl_state_t st_d, st_q;
    lvl_e       tgt;

    always_comb begin
        st_d          = st_q;
        st_d.erase    = 1'b0;
        st_d.erase_xo = 1'b0;
        tgt           = lvl_norm(req_code);
        if (req && lvl_step_ok(st_q.lvl, tgt)) begin
            st_d.lvl = tgt;
            if (st_q.lvl == LVL1 && tgt == LVL0) begin
                st_d.erase    = 1'b1;
                st_d.erase_xo = xo_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl      <= lvl_norm(lvl_init);
            st_q.erase    <= 1'b0;
            st_q.erase_xo <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl      = st_q.lvl;
    assign erase    = st_q.erase;
    assign erase_xo = st_q.erase_xo;
endmodule

// File: rtl/fg_rules.sv
module fg_rules
    import flash_guard_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       dbg,
    input  logic [1:0] boot,
    input  lvl_e       lvl,
    input  logic       xo_hit,
    input  logic       wp_hit,
    input  logic       sec_hit,
    input  logic       sec_locked,
    output logic       allow
);
    logic cpu_fetch, is_write;
    logic deny_lvl, deny_xo, deny_wp, deny_sec;

    always_comb begin
        cpu_fetch = (kind == KIND_FETCH) && !dbg;
        is_write  = kind[1];
        deny_lvl  = (lvl != LVL0) && (dbg || boot != BOOT_FLASH);
        deny_xo   = xo_hit && !cpu_fetch;
        deny_wp   = wp_hit && is_write;
        deny_sec  = sec_hit && sec_locked;
        allow     = !(deny_lvl || deny_xo || deny_wp || deny_sec);
    end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 32,
    parameter int XO_LSB   = 9,
    parameter int PAGE_LSB = 11,
    localparam int UW      = ADDR_W - XO_LSB,
    localparam int PGW     = ADDR_W - PAGE_LSB,
    localparam int NPAGES  = 1 << PGW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lvl_init,
    input  logic              lvl_req,
    input  logic [1:0]        lvl_req_code,
    input  logic              xo_erase_sel,
    input  logic [1:0]        boot_src,
    input  logic [UW-1:0]     xo_a_lo,
    input  logic [UW-1:0]     xo_a_hi,
    input  logic [UW-1:0]     xo_b_lo,
    input  logic [UW-1:0]     xo_b_hi,
    input  logic [NPAGES-1:0] wp_mask,
    input  logic [PGW:0]      sec_pages,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic              acc_dbg,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              grant,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic              violation,
    output logic [1:0]        lvl_cur,
    output logic              erase_req,
    output logic              erase_xo
);
    localparam int NWIN = 2;

    logic [UW-1:0]   win_lo [NWIN];
    logic [UW-1:0]   win_hi [NWIN];
    logic [NWIN-1:0] win_hit;
    logic [UW-1:0]   unit_idx;
    logic [PGW-1:0]  page_idx;
    logic            wp_hit, sec_hit, allow;
    lvl_e            lvl;
    guard_state_t    g_d, g_q;

    assign unit_idx  = acc_addr[ADDR_W-1:XO_LSB];
    assign page_idx  = acc_addr[ADDR_W-1:PAGE_LSB];
    assign win_lo[0] = xo_a_lo;
    assign win_hi[0] = xo_a_hi;
    assign win_lo[1] = xo_b_lo;
    assign win_hi[1] = xo_b_hi;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        fg_range_match #(.UW(UW)) u_rng (
            .unit_idx (unit_idx),
            .lo       (win_lo[w]),
            .hi       (win_hi[w]),
            .hit      (win_hit[w])
        );
    end

    assign wp_hit  = wp_mask[page_idx];
    assign sec_hit = {1'b0, page_idx} < sec_pages;

    fg_level_ctl u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_init (lvl_init),
        .req      (lvl_req),
        .req_code (lvl_req_code),
        .xo_sel   (xo_erase_sel),
        .lvl      (lvl),
        .erase    (erase_req),
        .erase_xo (erase_xo)
    );

    fg_rules u_rules (
        .kind       (acc_kind),
        .dbg        (acc_dbg),
        .boot       (boot_src),
        .lvl        (lvl),
        .xo_hit     (|win_hit),
        .wp_hit     (wp_hit),
        .sec_hit    (sec_hit),
        .sec_locked (g_q.sec_lock),
        .allow      (allow)
    );

    always_comb begin
        g_d          = g_q;
        g_d.viol     = acc_valid && !allow;
        if (acc_valid && acc_kind == KIND_FETCH && !acc_dbg && !sec_hit)
            g_d.sec_lock = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign grant     = acc_valid && allow;
    assign rd_data   = (grant && !acc_kind[1]) ? mem_rdata : '0;
    assign wr_en     = grant && acc_kind[1];
    assign violation = g_q.viol;
    assign lvl_cur   = lvl;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_dbg,
    input logic              lvl_req,
    input logic              grant,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic              violation,
    input logic [1:0]        lvl_cur,
    input logic              erase_req,
    input logic              erase_xo
);
    assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_cur != 2'b11);
    assert_no_req_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_req |=> $stable(lvl_cur));
    assert_lvl2_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_cur == 2'b10) |=> (lvl_cur == 2'b10));
    assert_erase_on_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (lvl_cur == 2'b00 && $past(lvl_cur) == 2'b01));
    assert_erase_xo_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_xo |-> erase_req);
    assert_dbg_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_dbg && lvl_cur != 2'b00) |-> !grant);
    assert_viol_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !grant) |=> violation);
    assert_viol_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !grant) |=> !violation);
    assert_wr_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> grant);
    assert_rd_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != '0) |-> grant);
endmodule

bind flash_guard flash_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_dbg   (acc_dbg),
    .lvl_req   (lvl_req),
    .grant     (grant),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .violation (violation),
    .lvl_cur   (lvl_cur),
    .erase_req (erase_req),
    .erase_xo  (erase_xo)
);

// File: tb/flash_guard_tb_top.sv
module flash_guard_tb_top;
    localparam int AW  = 14;
    localparam int DW  = 32;
    localparam int UW  = AW - 9;
    localparam int PGW = AW - 11;
    localparam int NP  = 1 << PGW;
    localparam logic [DW-1:0] RD = 32'hA5C3_0F01;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    lvl_init = 2'b00;
    logic          lvl_req = 1'b0;
    logic [1:0]    lvl_req_code = 2'b00;
    logic          xo_erase_sel = 1'b0;
    logic [1:0]    boot_src = 2'b00;
    logic [UW-1:0] xo_a_lo = 5'd1, xo_a_hi = 5'd0, xo_b_lo = 5'd1, xo_b_hi = 5'd0;
    logic [NP-1:0] wp_mask = '0;
    logic [PGW:0]  sec_pages = '0;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_kind = 2'b00;
    logic          acc_dbg = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] mem_rdata = RD;
    logic          grant, wr_en, violation, erase_req, erase_xo;
    logic [DW-1:0] rd_data;
    logic [1:0]    lvl_cur;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    flash_guard #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] init, input logic [1:0] exp_lvl);
        @(negedge clk);
        rst_n = 1'b0;
        lvl_init = init;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 reset level", 32'(lvl_cur), 32'(exp_lvl));
        chk("R9 reset violation", 32'(violation), 0);
        chk("R4 reset erase", 32'(erase_req), 0);
    endtask

    // drive one access, check same-cycle outputs, then the violation pulse
    task automatic do_acc(input string tag, input logic [1:0] kind, input logic dbg,
                          input logic [AW-1:0] addr, input logic exp_g);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_kind  = kind;
        acc_dbg   = dbg;
        acc_addr  = addr;
        #1;
        chk({tag, " grant"}, 32'(grant), 32'(exp_g));
        chk({tag, " R9/R10 rd_data"}, rd_data, (exp_g && !kind[1]) ? RD : 32'h0);
        chk({tag, " R9/R10 wr_en"}, 32'(wr_en), 32'(exp_g && kind[1]));
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
        chk({tag, " R9 violation"}, 32'(violation), 32'(!exp_g));
        @(negedge clk);
        #1;
        chk({tag, " R9 violation width"}, 32'(violation), 0);
    endtask

    task automatic lvl_chg(input string tag, input logic [1:0] code, input logic [1:0] exp_l,
                           input logic exp_e, input logic exp_x);
        @(negedge clk);
        lvl_req = 1'b1;
        lvl_req_code = code;
        @(negedge clk);
        lvl_req = 1'b0;
        #1;
        chk({tag, " level"}, 32'(lvl_cur), 32'(exp_l));
        chk({tag, " R4 erase_req"}, 32'(erase_req), 32'(exp_e));
        chk({tag, " R4 erase_xo"}, 32'(erase_xo), 32'(exp_x));
        @(negedge clk);
        #1;
        chk({tag, " R4 erase drop"}, 32'(erase_req | erase_xo), 0);
        chk({tag, " level hold"}, 32'(lvl_cur), 32'(exp_l));
    endtask

    task automatic t_reset_codes;
        do_reset(2'b00, 2'b00);
        do_reset(2'b11, 2'b01);
        do_reset(2'b10, 2'b10);
        do_reset(2'b01, 2'b01);
    endtask

    task automatic t_levels;
        do_reset(2'b00, 2'b00);
        lvl_chg("R3 0->0", 2'b00, 2'b00, 0, 0);
        lvl_chg("R2 0->1", 2'b01, 2'b01, 0, 0);
        xo_erase_sel = 1'b1;
        lvl_chg("R2 1->0 xo", 2'b00, 2'b00, 1, 1);
        lvl_chg("R2 0->2", 2'b10, 2'b10, 0, 0);
        lvl_chg("R3 2->0", 2'b00, 2'b10, 0, 0);
        lvl_chg("R3 2->1", 2'b01, 2'b10, 0, 0);
        do_reset(2'b00, 2'b00);
        lvl_chg("R2 0->11", 2'b11, 2'b01, 0, 0);
        lvl_chg("R3 1->11", 2'b11, 2'b01, 0, 0);
        xo_erase_sel = 1'b0;
        lvl_chg("R4 1->0 noxo", 2'b00, 2'b00, 1, 0);
        lvl_chg("R2 0->1b", 2'b01, 2'b01, 0, 0);
        lvl_chg("R2 1->2", 2'b10, 2'b10, 0, 0);
    endtask

    task automatic t_readout;
        do_reset(2'b00, 2'b00);
        do_acc("R5 L0 dbg read", 2'b01, 1, 14'h0100, 1);
        do_acc("R10 L0 write", 2'b10, 0, 14'h0200, 1);
        boot_src = 2'b01;
        do_acc("R5 L0 sram boot read", 2'b01, 0, 14'h0100, 1);
        boot_src = 2'b00;
        do_reset(2'b01, 2'b01);
        do_acc("R5 L1 dbg read", 2'b01, 1, 14'h0100, 0);
        do_acc("R10 L1 cpu read", 2'b01, 0, 14'h0100, 1);
        boot_src = 2'b01;
        do_acc("R5 L1 sram boot fetch", 2'b00, 0, 14'h0100, 0);
        boot_src = 2'b10;
        do_acc("R5 L1 loader read", 2'b01, 0, 14'h0100, 0);
        boot_src = 2'b00;
        do_reset(2'b10, 2'b10);
        do_acc("R5 L2 dbg fetch", 2'b00, 1, 14'h0100, 0);
        do_acc("R10 L2 cpu fetch", 2'b00, 0, 14'h0100, 1);
    endtask

    task automatic t_xo;
        do_reset(2'b00, 2'b00);
        xo_a_lo = 5'd2; xo_a_hi = 5'd3;
        xo_b_lo = 5'd31; xo_b_hi = 5'd31;
        do_acc("R6 A fetch lo", 2'b00, 0, 14'h0400, 1);
        do_acc("R6 A read lo", 2'b01, 0, 14'h0400, 0);
        do_acc("R6 below A", 2'b01, 0, 14'h03FC, 1);
        do_acc("R6 A read hi", 2'b01, 0, 14'h07FC, 0);
        do_acc("R6 above A", 2'b01, 0, 14'h0800, 1);
        do_acc("R6 A write", 2'b10, 0, 14'h0600, 0);
        do_acc("R6 A dbg fetch", 2'b00, 1, 14'h0400, 0);
        do_acc("R6 B top read", 2'b01, 0, 14'h3FFC, 0);
        do_acc("R6 B top fetch", 2'b00, 0, 14'h3E00, 1);
        do_acc("R6 below B", 2'b01, 0, 14'h3DFC, 1);
        xo_b_lo = 5'd10; xo_b_hi = 5'd9;
        do_acc("R6 B off", 2'b01, 0, 14'h3FFC, 1);
        xo_a_lo = 5'd1; xo_a_hi = 5'd0; xo_b_lo = 5'd1; xo_b_hi = 5'd0;
    endtask

    task automatic t_wp;
        do_reset(2'b00, 2'b00);
        wp_mask = 8'h80;
        do_acc("R7 wp write", 2'b10, 0, 14'h3800, 0);
        do_acc("R7 wp write11", 2'b11, 0, 14'h3FFC, 0);
        do_acc("R7 wp read", 2'b01, 0, 14'h3800, 1);
        do_acc("R7 wp fetch", 2'b00, 0, 14'h3900, 1);
        do_acc("R7 neighbour write", 2'b10, 0, 14'h37FC, 1);
        wp_mask = '0;
        do_acc("R7 unprotected", 2'b10, 0, 14'h3800, 1);
    endtask

    task automatic t_sec;
        sec_pages = 4'd2;
        do_reset(2'b00, 2'b00);
        do_acc("R8 inside read", 2'b01, 0, 14'h0100, 1);
        do_acc("R8 inside fetch", 2'b00, 0, 14'h0FFC, 1);
        do_acc("R8 dbg outside fetch", 2'b00, 1, 14'h1000, 1);
        do_acc("R8 still open", 2'b01, 0, 14'h0100, 1);
        do_acc("R8 leaving fetch", 2'b00, 0, 14'h1000, 1);
        do_acc("R8 locked read", 2'b01, 0, 14'h0100, 0);
        do_acc("R8 locked fetch", 2'b00, 0, 14'h0FFC, 0);
        do_acc("R8 outside read", 2'b01, 0, 14'h1000, 1);
        do_reset(2'b00, 2'b00);
        do_acc("R8 reopened", 2'b01, 0, 14'h0100, 1);
        sec_pages = 4'd8;
        do_acc("R8 full fetch", 2'b00, 0, 14'h3FFC, 1);
        do_acc("R8 full no lock", 2'b01, 0, 14'h0000, 1);
        sec_pages = '0;
    endtask

    initial begin
        t_reset_codes();
        t_levels();
        t_readout();
        t_xo();
        t_wp();
        t_sec();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule